// File: doc/BRIEF.md
# Lockable Indexed Configuration Register File

This block is the configuration register bank of a multi-function peripheral controller. The host sees two ports: an index port and a data port. It first writes an 8-bit index that selects one of the configuration registers 00h through 2Fh. It then reads or writes that register through the data port.

All access is gated by a configuration-state input. A surrounding block asserts this input once the host has entered configuration state. Registers 00h and 01h carry control bits for other logic: power enables, a mode select and a software-only valid flag. Their reserved bits read back fixed constants, some 0 and some 1.

Bit 7 of register 01h is an access-enable bit. Once software clears it, every read and write in the 00h–2Fh range is blocked. Only a hard reset sets it again.

Top module: `cfg_regfile`

## Requirements
- R1: After reset the index is 00h. Register 00h reads 28h, register 01h reads 9Ch, and registers 02h–2Fh read 00h. The control outputs come out of reset as follows: access_open=1, cfg_valid=0, aux_basic_mode=1, aux_pwr_en=1, main_pwr_en=1.
- R2: While cfg_mode is 0, the following hold:
  - rdata is 00h.
  - Index writes are ignored.
  - Data writes are ignored.
- R3: In register 00h only bits 3 and 7 are writable. The other bits always read as fixed values: bits 2:0 read 000, bit 4 reads 0, bit 5 reads 1 and bit 6 reads 0. As a result, writing FFh reads back A8h and writing 00h reads back 20h.
- R4: Register 00h bit 3 drives main_pwr_en, where 1 means powered. Register 00h bit 7 drives cfg_valid, a flag that software sets and clears.
- R5: In register 01h only bits 2, 3 and 7 are writable. The other bits always read as fixed values: bits 1:0 read 00, bit 4 reads 1 and bits 6:5 read 00. As a result, writing 80h reads back 90h.
- R6: Register 01h bit 2 drives aux_pwr_en. Register 01h bit 3 drives aux_basic_mode, where 1 selects the basic mode and 0 the extended modes.
- R7: Register 01h bit 7 drives access_open. While it is 0, the following hold:
  - rdata is 00h for every index.
  - Data writes change no register.
  - Index writes still work.
- R8: Once access_open is 0, no data-port write can set it back to 1. Only the reset input sets it back to 1.
- R9: Indices 30h–FFh select no register. Reads at these indices return 00h, and writes at them change nothing.
- R10: Registers 02h–2Fh are plain 8-bit read/write storage.
- R11: A data write is accepted when all of the following hold: data_we=1, cfg_mode=1, access_open=1 and the index is in range. An accepted write updates the register on that rising clock edge. rdata follows the index and the register contents combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| cfg_mode | input | 1 | Configuration state is active |
| idx_we | input | 1 | Write wdata into the index register |
| data_we | input | 1 | Write wdata into the selected register |
| wdata | input | 8 | Write data for index or data port |
| rdata | output | 8 | Data-port read value |
| main_pwr_en | output | 1 | Power enable from register 00h bit 3 |
| cfg_valid | output | 1 | Software valid flag from register 00h bit 7 |
| aux_pwr_en | output | 1 | Power enable from register 01h bit 2 |
| aux_basic_mode | output | 1 | Mode select from register 01h bit 3 |
| access_open | output | 1 | Access enable from register 01h bit 7 |

## Verification
A corrupted register bit shows up on rdata in the same cycle the index selects it. For register 00h and register 01h it also shows up at once on the decoded control outputs.

A faulty lock gate shows as one of two port symptoms:
- a register whose value changes while access_open is low, seen through main_pwr_en;
- access_open returning to 1 after a data write.

A faulty read-only mask shows as a wrong constant on the first read after a write of all ones or all zeros. Each of these faults therefore appears within one or two cycles of the stimulus that exposes it.

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NREG = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_mode,
  input  logic       idx_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       main_pwr_en,
  output logic       cfg_valid,
  output logic       aux_pwr_en,
  output logic       aux_basic_mode,
  output logic       access_open
);

  localparam int AW = $clog2(NREG);
  localparam logic [7:0] NREG_B = 8'(NREG);

  function automatic logic [7:0] wr_mask(int i);
    case (i)
      0:       return 8'h88;
      1:       return 8'h8C;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] fixed_val(int i);
    case (i)
      0:       return 8'h20;
      1:       return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(int i);
    case (i)
      0:       return 8'h28;
      1:       return 8'h9C;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] idx;
  logic [7:0] regs [NREG];

  wire in_range = idx < NREG_B;
  wire open_now = regs[1][7];
  wire rd_ok    = cfg_mode && open_now && in_range;
  wire wr_ok    = cfg_mode && data_we && open_now && in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= 8'h00;
    else if (cfg_mode && idx_we)
      idx <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rst_val(i);
    end else if (wr_ok) begin
      for (int i = 0; i < NREG; i++) begin
        if (idx == 8'(i)) begin
          regs[i] <= (wdata & wr_mask(i)) | fixed_val(i);
          if (i == 1) regs[i][7] <= wdata[7] & open_now;
        end
      end
    end
  end

  assign rdata          = rd_ok ? regs[idx[AW-1:0]] : 8'h00;
  assign main_pwr_en    = regs[0][3];
  assign cfg_valid      = regs[0][7];
  assign aux_pwr_en     = regs[1][2];
  assign aux_basic_mode = regs[1][3];
  assign access_open    = open_now;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !access_open |=> !access_open); // R8
  AST_LOCKED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !access_open |-> rdata == 8'h00); // R7
  AST_LOCKED_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !access_open |=> $stable(main_pwr_en) && $stable(aux_pwr_en)); // R7
  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> rdata == 8'h00); // R2
  AST_OUTSIDE_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(idx)); // R2
  AST_OUTSIDE_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(main_pwr_en) && $stable(cfg_valid) && $stable(aux_basic_mode)); // R2
  AST_R0_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && access_open && idx == 8'h00) |-> (rdata[6:4] == 3'b010 && rdata[2:0] == 3'b000)); // R3
  AST_R1_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && access_open && idx == 8'h01) |-> (rdata[6:4] == 3'b001 && rdata[1:0] == 2'b00)); // R5
  AST_HIGH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= NREG_B) |-> rdata == 8'h00); // R9

endmodule

// File: tb/sim_cfg_regfile.sv
module sim_cfg_regfile;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_mode = 1'b0;
  logic       idx_we = 1'b0;
  logic       data_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       main_pwr_en, cfg_valid, aux_pwr_en, aux_basic_mode, access_open;

  cfg_regfile u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .idx_we(idx_we),
    .data_we(data_we), .wdata(wdata), .rdata(rdata),
    .main_pwr_en(main_pwr_en), .cfg_valid(cfg_valid), .aux_pwr_en(aux_pwr_en),
    .aux_basic_mode(aux_basic_mode), .access_open(access_open)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [12:0] exp;
    logic [12:0] mask;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  logic  smp = 1'b0;
  bit    done = 1'b0;

  localparam logic [12:0] M_DATA = 13'h00FF;
  localparam logic [12:0] M_ALL  = 13'h1FFF;

  wire [12:0] obs = {access_open, cfg_valid, aux_basic_mode, aux_pwr_en, main_pwr_en, rdata};

  function automatic logic [12:0] ctl(logic ao, logic cv, logic bm, logic ap, logic mp, logic [7:0] d);
    return {ao, cv, bm, ap, mp, d};
  endfunction

  always @(negedge clk) begin
    if (smp) begin
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h expected item", obs);
      end else begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: actual %h expected %h (mask %h)", it.tag, obs & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic expect_obs(logic [12:0] e, logic [12:0] m, string tag);
    @(posedge clk); #1;
    q.push_back('{exp: e, mask: m, tag: tag});
    smp = 1'b1;
    @(posedge clk); #1;
    smp = 1'b0;
  endtask

  task automatic set_idx(logic [7:0] v);
    @(posedge clk); #1;
    idx_we = 1'b1; wdata = v;
    @(posedge clk); #1;
    idx_we = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] v);
    @(posedge clk); #1;
    data_we = 1'b1; wdata = v;
    @(posedge clk); #1;
    data_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] i, logic [7:0] e, string tag);
    set_idx(i);
    expect_obs({5'b0, e}, M_DATA, tag);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    cfg_mode = 1'b1;

    // R1 reset values and outputs, index starts at 00h
    expect_obs(ctl(1, 0, 1, 1, 1, 8'h28), M_ALL, "R1 reset idx0/outputs");
    rd(8'h01, 8'h9C, "R1 reg01 default");
    rd(8'h05, 8'h00, "R1 reg05 default");
    rd(8'h2F, 8'h00, "R1 reg2F default");

    // R10 R11 general storage, readable right after the write edge
    wr_data(8'hA5);
    expect_obs({5'b0, 8'hA5}, M_DATA, "R11 reg2F write visible");
    set_idx(8'h02);
    wr_data(8'h3C);
    expect_obs({5'b0, 8'h3C}, M_DATA, "R10 reg02 write");
    rd(8'h2F, 8'hA5, "R10 reg2F kept");

    // R3 R4 register 00h
    set_idx(8'h00);
    wr_data(8'hFF);
    expect_obs(ctl(1, 1, 1, 1, 1, 8'hA8), M_ALL, "R3 R4 reg00 all ones");
    wr_data(8'h00);
    expect_obs(ctl(1, 0, 1, 1, 0, 8'h20), M_ALL, "R3 R4 reg00 all zeros");
    wr_data(8'h08);
    expect_obs(ctl(1, 0, 1, 1, 1, 8'h28), M_ALL, "R4 main power back on");

    // R5 R6 register 01h
    set_idx(8'h01);
    wr_data(8'h80);
    expect_obs(ctl(1, 0, 0, 0, 1, 8'h90), M_ALL, "R5 R6 reg01 write 80h");
    wr_data(8'h7F);
    expect_obs(ctl(0, 0, 1, 1, 1, 8'h00), M_ALL, "R5 reg01 write 7Fh locks");
    do_reset();
    rd(8'h01, 8'h9C, "R8 reset reopens access");
    wr_data(8'h84);
    expect_obs(ctl(1, 0, 0, 1, 1, 8'h94), M_ALL, "R6 aux power only");
    wr_data(8'h8C);
    expect_obs(ctl(1, 0, 1, 1, 1, 8'h9C), M_ALL, "R6 restore reg01");

    // R9 out of range indices
    set_idx(8'h2E);
    wr_data(8'h5A);
    rd(8'h30, 8'h00, "R9 index 30h reads zero");
    wr_data(8'h77);
    rd(8'hFF, 8'h00, "R9 index FFh reads zero");
    rd(8'h2E, 8'h5A, "R9 neighbour unchanged");
    rd(8'h2F, 8'h00, "R9 reg2F unchanged");

    // R2 outside configuration state
    set_idx(8'h2E);
    @(posedge clk); #1 cfg_mode = 1'b0;
    expect_obs({5'b0, 8'h00}, M_DATA, "R2 read blocked");
    wr_data(8'h11);
    set_idx(8'h00);
    wr_data(8'h00);
    expect_obs(ctl(1, 0, 1, 1, 1, 8'h00), M_ALL, "R2 outputs unchanged");
    @(posedge clk); #1 cfg_mode = 1'b1;
    expect_obs({5'b0, 8'h5A}, M_DATA, "R2 index and data untouched");

    // R7 R8 lock
    set_idx(8'h01);
    wr_data(8'h0C);
    expect_obs(ctl(0, 0, 1, 1, 1, 8'h00), M_ALL, "R7 lock cleared, reads zero");
    rd(8'h2E, 8'h00, "R7 locked read reg2E");
    set_idx(8'h00);
    wr_data(8'h00);
    expect_obs(ctl(0, 0, 1, 1, 1, 8'h00), M_ALL, "R7 locked write ignored");
    set_idx(8'h01);
    wr_data(8'hFF);
    expect_obs(ctl(0, 0, 1, 1, 1, 8'h00), M_ALL, "R8 lock stays cleared");
    do_reset();
    expect_obs(ctl(1, 0, 1, 1, 1, 8'h28), M_ALL, "R8 reset restores access");
    rd(8'h2E, 8'h00, "R1 storage cleared by reset");

    done = 1'b1;
    finish_run();
  end

endmodule